// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Engine

This engine moves received frames from a byte-wide stream into memory. Software builds a circular chain of four-word receive descriptors, each naming a buffer and its capacity. It hands the address of the first one to the engine and issues a start command. The engine walks the chain and fills one buffer per frame. After each frame it writes a status word back into the descriptor, marking it complete and recording the byte count. Software then reads the frame, clears the status and releases the descriptor again.

Two conditions make a descriptor unusable, and reception stops at either one. The first is a hold mark in its control word, which lets software fence off the part of the ring it still owns. The second is a status word that still shows completion from an earlier lap. While stopped, the engine holds the stream back and re-reads the descriptor after a programmable number of idle cycles. A frame longer than its buffer is cut at the buffer size, reported as incomplete, and the rest of it is discarded. Three sticky event flags are cleared by writing ones.

Top module: `rx_ring_dma`

## Requirements
- R1: After reset the engine is idle. `s_ready` is 0, `mem_req` is 0 and `irq_flags` is 0, and nothing changes until `cmd_init`.
- R2: A `cmd_init` pulse latches `cfg_ring_base`. The first memory read that follows is at that address.
- R3: Each descriptor is four 32-bit words at byte offsets 0, 4, 8 and 12. Word 0 is control, word 1 is the next-descriptor address, word 2 is the buffer address and word 3 is status. Frame byte k is written to buffer address + k. The write goes to the word-aligned address with the single byte enable `mem_be[addr[1:0]]` set, and all four byte lanes of `mem_wdata` carry the byte.
- R4: When a frame ends within its buffer, word 3 is written with all four byte enables. The value has bit 31 (complete) = 1, bit 30 (start of frame) = 1, bit 29 (end of frame) = 1, bits 16:0 = number of stream bytes received (check sequence included) and all other bits 0.
- R5: After the status write-back, the engine moves to the descriptor named by word 1. The last descriptor's link back to the first makes the ring wrap.
- R6: If bit 31 of word 0 (hold) is set, the descriptor is not written and `s_ready` stays 0. Once software clears the bit, the next poll fills it.
- R7: If bit 31 of word 3 is still set, the descriptor is treated as not yet released. It is not written and `s_ready` stays 0.
- R8: The buffer size is word 0 bits 21:0. A byte that arrives once that many bytes are stored is not written. Status is written with complete = 1, start = 1, end = 0 and count = buffer size. The rest of the frame is accepted and discarded, and the next frame uses the next descriptor.
- R9: `irq_flags` bit 0 is set at a write-back when word 0 bit 30 is 1. Bit 1 is set at a write-back that ends with end-of-frame when word 0 bit 29 is 1. Bit 2 is set at a truncated write-back. A write with `flag_clr_we` clears every bit given as 1 in `flag_clr`, so all ones clears all three. A set in the same cycle wins.
- R10: A `cmd_off` pulse stops the engine. `s_ready` and `mem_req` stay 0 until the next `cmd_init`.
- R11: After finding a descriptor unusable, the engine waits `cfg_poll` + 1 idle cycles before re-reading it. Successive reads of its word 0 are therefore `cfg_poll` + 6 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_init | input | 1 | Start pulse; latches the ring base |
| cmd_off | input | 1 | Stop pulse |
| cfg_ring_base | input | AW | Byte address of the first descriptor |
| cfg_poll | input | PW | Idle cycles between polls, minus one |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 3 | Ones clear the matching flags |
| irq_flags | output | 3 | Sticky event flags |

## Verification
The bench places a buffer on an odd address so that byte lanes rotate. A design that assumed alignment would write bytes into the wrong lanes. It parks the engine on a held descriptor and then on one whose status is still complete. A design that skipped either test would overwrite memory that software owns, or would raise ready. It overruns a small buffer and checks three things: the cut status word, untouched memory past the limit, and the next frame landing in the next descriptor. A design that kept writing or lost its place would fail one of these. It also times the spacing of polls and checks that a stop command silences the memory port.

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int AW = 32,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_init,
  input  logic          cmd_off,
  input  logic [AW-1:0] cfg_ring_base,
  input  logic [PW-1:0] cfg_poll,
  input  logic          s_valid,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          flag_clr_we,
  input  logic [2:0]    flag_clr,
  output logic [2:0]    irq_flags
);
  localparam int SZW = 22;
  localparam int CNTW = 17;

  typedef enum logic [2:0] {S_OFF, S_FETCH, S_CHECK, S_WAIT, S_RECV, S_WB, S_DROP} st_t;
  st_t st;

  logic [1:0]     fidx;
  logic [AW-1:0]  cur, nxt, bufa;
  logic           d_hold, d_ic, d_ieop;
  logic [SZW-1:0] d_size, cnt;
  logic [PW-1:0]  pollc;
  logic           ovf, drop;

  wire [AW-1:0] byte_addr = bufa + AW'(cnt);
  wire          full      = cnt == d_size;
  wire          hs        = s_valid && s_ready;
  wire          busy_desc = d_hold || mem_rdata[31];

  assign s_ready = (st == S_RECV) || (st == S_DROP);
  assign mem_req = (st == S_FETCH) || (st == S_WB) || (st == S_RECV && s_valid && !full);
  assign mem_we  = st != S_FETCH;

  always_comb begin
    mem_addr  = {byte_addr[AW-1:2], 2'b00};
    mem_be    = 4'b0001 << byte_addr[1:0];
    mem_wdata = {4{s_data}};
    if (st == S_FETCH) begin
      mem_addr = cur + AW'({fidx, 2'b00});
      mem_be   = 4'b0000;
    end else if (st == S_WB) begin
      mem_addr  = cur + AW'(12);
      mem_be    = 4'b1111;
      mem_wdata = {2'b11, !ovf, 12'b0, cnt[CNTW-1:0]};
    end else if (st != S_RECV) begin
      mem_be = 4'b0000;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_OFF;
      fidx   <= '0;
      cur    <= '0;
      nxt    <= '0;
      bufa   <= '0;
      d_hold <= 1'b0;
      d_ic   <= 1'b0;
      d_ieop <= 1'b0;
      d_size <= '0;
      cnt    <= '0;
      pollc  <= '0;
      ovf    <= 1'b0;
      drop   <= 1'b0;
    end else if (cmd_off) begin
      st <= S_OFF;
    end else if (cmd_init) begin
      cur  <= cfg_ring_base;
      fidx <= '0;
      st   <= S_FETCH;
    end else begin
      case (st)
        S_FETCH: begin
          case (fidx)
            2'd1: begin
              d_hold <= mem_rdata[31];
              d_ic   <= mem_rdata[30];
              d_ieop <= mem_rdata[29];
              d_size <= mem_rdata[SZW-1:0];
            end
            2'd2: nxt  <= mem_rdata[AW-1:0];
            2'd3: bufa <= mem_rdata[AW-1:0];
            default: ;
          endcase
          fidx <= fidx + 2'd1;
          if (fidx == 2'd3) st <= S_CHECK;
        end
        S_CHECK: begin
          if (busy_desc) begin
            pollc <= cfg_poll;
            st    <= S_WAIT;
          end else begin
            cnt  <= '0;
            ovf  <= 1'b0;
            drop <= 1'b0;
            st   <= S_RECV;
          end
        end
        S_WAIT: begin
          if (pollc == '0) begin
            fidx <= '0;
            st   <= S_FETCH;
          end else begin
            pollc <= pollc - 1'b1;
          end
        end
        S_RECV: begin
          if (hs) begin
            if (full) begin
              ovf  <= 1'b1;
              drop <= !s_last;
              st   <= S_WB;
            end else begin
              cnt <= cnt + 1'b1;
              if (s_last) st <= S_WB;
            end
          end
        end
        S_WB: begin
          cur  <= nxt;
          fidx <= '0;
          st   <= drop ? S_DROP : S_FETCH;
        end
        S_DROP: begin
          if (hs && s_last) begin
            fidx <= '0;
            st   <= S_FETCH;
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end

  wire [2:0] flag_set = (st == S_WB) ? {ovf, d_ieop && !ovf, d_ic} : 3'b000;
  wire [2:0] flag_off = flag_clr_we ? flag_clr : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_flags <= '0;
    else        irq_flags <= (irq_flags & ~flag_off) | flag_set;
  end
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
  parameter int AW = 32,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_init,
  input logic          cmd_off,
  input logic          s_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_wdata,
  input logic          flag_clr_we,
  input logic [2:0]    flag_clr,
  input logic [2:0]    irq_flags
);
  wire stat_wr = mem_req && mem_we && (mem_be == 4'hF);
  wire byte_wr = mem_req && mem_we && (mem_be != 4'hF);

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_off && !cmd_init) |=> (!s_ready && !mem_req)) else $error("off");  // R10
  AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr |-> $onehot(mem_be)) else $error("lane");  // R3
  AST_STATUS_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |-> (mem_wdata[31] && mem_wdata[30] && mem_wdata[28:17] == 12'b0)) else $error("status");  // R4
  AST_NO_FETCH_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !(mem_req && !mem_we)) else $error("fetch");  // R6
  AST_FLAGS_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_we && flag_clr == 3'b111 && !stat_wr) |=> (irq_flags == 3'b000)) else $error("clr");  // R9
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_clr_we && !stat_wr) |=> $stable(irq_flags)) else $error("stable");  // R9
endmodule

bind rx_ring_dma rx_ring_dma_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_init(cmd_init), .cmd_off(cmd_off),
  .s_ready(s_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be),
  .mem_wdata(mem_wdata), .flag_clr_we(flag_clr_we), .flag_clr(flag_clr),
  .irq_flags(irq_flags)
);

// File: tb/rx_ring_dma_test.sv
module rx_ring_dma_test;
  localparam int CLK_PERIOD = 10;
  localparam int POLL = 5;

  logic clk = 0, rst_n = 0, cmd_init = 0, cmd_off = 0;
  logic [31:0] cfg_ring_base = 0;
  logic [7:0] cfg_poll = POLL;
  logic s_valid = 0, s_last = 0;
  logic [7:0] s_data = 0;
  logic s_ready, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic flag_clr_we = 0;
  logic [2:0] flag_clr = 0;
  logic [2:0] irq_flags;

  int checks = 0, failures = 0, cyc = 0, req_cnt = 0;
  int t_prev = -1, t_last = -1;
  logic [31:0] first_rd = 32'hFFFF_FFFF;
  bit seen_rd = 0, done = 0;
  logic [31:0] mem [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_dma uut (.*);

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_req) req_cnt = req_cnt + 1;
    if (mem_req && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
    end
    if (mem_req && !mem_we) begin
      mem_rdata <= mem[mem_addr[9:2]];
      if (!seen_rd) begin seen_rd = 1; first_rd = mem_addr; end
      if (mem_addr == 32'h20) begin t_prev = t_last; t_last = cyc; end
    end
  end

  function automatic logic [31:0] ctl(bit hold, bit ic, bit ieop, int size);
    return {hold, ic, ieop, 7'b0, 22'(size)};
  endfunction

  function automatic logic [7:0] rbyte(int a);
    return mem[a >> 2][8*(a & 3) +: 8];
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_frame(int n, logic [7:0] seed);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      s_valid = 1; s_data = seed + 8'(k); s_last = (k == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 0; s_last = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_bytes(int base, int n, logic [7:0] seed, string req);
    for (int k = 0; k < n; k++)
      chk(rbyte(base + k) == seed + 8'(k), req, 32'(rbyte(base + k)), 32'(seed + 8'(k)));
  endtask

  task automatic clear_flags(logic [2:0] m);
    @(negedge clk); flag_clr_we = 1; flag_clr = m;
    @(negedge clk); flag_clr_we = 0; flag_clr = 0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(s_ready == 0 && mem_req == 0, "R1", {30'b0, s_ready, mem_req}, 0);
    chk(irq_flags == 0, "R1", 32'(irq_flags), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(mem_req == 0 && !seen_rd, "R1", 32'(mem_req), 0);
  endtask

  task automatic t_init;
    cmd_init = 1; @(negedge clk); cmd_init = 0;
    repeat (3) @(negedge clk);
    chk(first_rd == 32'h0, "R2", first_rd, 0);
  endtask

  task automatic t_first_frame;
    send_frame(10, 8'h10);
    check_bytes(32'h100, 10, 8'h10, "R3");
    chk(mem[3] == 32'hE000_000A, "R4", mem[3], 32'hE000_000A);
    chk(irq_flags == 3'b011, "R9", 32'(irq_flags), 3);
  endtask

  task automatic t_flags;
    clear_flags(3'b001);
    chk(irq_flags == 3'b010, "R9", 32'(irq_flags), 2);
    clear_flags(3'b111);
    chk(irq_flags == 3'b000, "R9", 32'(irq_flags), 0);
  endtask

  task automatic t_unaligned;
    send_frame(7, 8'h40);
    check_bytes(32'h181, 7, 8'h40, "R3");
    chk(mem[7] == 32'hE000_0007, "R5", mem[7], 32'hE000_0007);
    chk(irq_flags == 3'b000, "R9", 32'(irq_flags), 0);
  endtask

  task automatic t_hold;
    repeat (40) @(negedge clk);
    chk(s_ready == 0, "R6", 32'(s_ready), 0);
    chk(mem[11] == 0, "R6", mem[11], 0);
    chk(t_prev > 0 && (t_last - t_prev) == POLL + 6, "R11", 32'(t_last - t_prev), POLL + 6);
    mem[8] = ctl(0, 0, 0, 64);
    send_frame(5, 8'h80);
    check_bytes(32'h200, 5, 8'h80, "R6");
    chk(mem[11] == 32'hE000_0005, "R6", mem[11], 32'hE000_0005);
  endtask

  task automatic t_busy_and_overflow;
    repeat (30) @(negedge clk);
    chk(s_ready == 0, "R7", 32'(s_ready), 0);
    chk(mem[3] == 32'hE000_000A, "R7", mem[3], 32'hE000_000A);
    mem[64] = 0; mem[65] = 0; mem[66] = 0;
    mem[0] = ctl(0, 1, 1, 8);
    mem[3] = 0;
    send_frame(12, 8'hA0);
    chk(mem[3] == 32'hC000_0008, "R8", mem[3], 32'hC000_0008);
    check_bytes(32'h100, 8, 8'hA0, "R5");
    chk(mem[66] == 0, "R8", mem[66], 0);
    chk(irq_flags == 3'b101, "R8", 32'(irq_flags), 5);
    clear_flags(3'b111);
    mem[7] = 0;
    send_frame(3, 8'hC0);
    check_bytes(32'h181, 3, 8'hC0, "R8");
    chk(mem[7] == 32'hE000_0003, "R8", mem[7], 32'hE000_0003);
  endtask

  task automatic t_off;
    cmd_off = 1; @(negedge clk); cmd_off = 0;
    req_cnt = 0;
    repeat (20) @(negedge clk);
    chk(req_cnt == 0, "R10", 32'(req_cnt), 0);
    chk(s_ready == 0, "R10", 32'(s_ready), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    mem[0] = ctl(0, 1, 1, 64); mem[1] = 32'h10; mem[2] = 32'h100;
    mem[4] = ctl(0, 0, 0, 64); mem[5] = 32'h20; mem[6] = 32'h181;
    mem[8] = ctl(1, 0, 0, 64); mem[9] = 32'h00; mem[10] = 32'h200;
    t_reset;
    t_init;
    t_first_frame;
    t_flags;
    t_unaligned;
    t_hold;
    t_busy_and_overflow;
    t_off;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule